// File: doc/BRIEF.md
# Crossing Peak Finder with Energy Table

This block sits behind a digital pulse-shaping filter that delivers 11-bit samples at twice the bunch-crossing rate, so each crossing owns two samples. It looks for the top of each pulse with a three-sample local-maximum test and reduces the stream to one value per crossing. That value addresses a 2048-entry table, which returns an 8-bit transverse-energy word. The table holds the calibration and the clipping or saturation curve, so any such curve can be loaded.

A sample strobe qualifies each filter sample, and a second flag marks the first of the two samples in a crossing. The decision for a crossing is taken when the first sample of the following crossing arrives, because that sample is the later neighbour of the crossing's second sample. A mode input bypasses the peak test and sends the crossing's second sample straight to the table, with the same latency. The table is written through an address/data port that is only honoured while a load-enable input is high.

Top module: `bxpk_et_top`

## Requirements
- R1: While reset is low and on the first clock after it, et_vld is 0 and et_out is 0. The sample history also clears to zero.
- R2: Each accepted sample with smp_first high causes exactly one et_vld pulse, two clock edges later. The latency is the same in both modes, and et_vld is never high at any other time.
- R3: In peak mode, a sample counts as a peak when it is strictly greater than the accepted sample before it and greater than or equal to the accepted sample after it. Cycles with smp_vld low are skipped and do not count as samples.
- R4: A flat top of equal values yields exactly one peak, on the first sample of the plateau. At most one of a crossing's two samples is ever reported.
- R5: In peak mode, when neither sample of a crossing is a peak, et_out carries the table entry at address 0.
- R6: The decision for a crossing uses four samples: the accepted sample before the crossing, the crossing's first sample (smp_first=1), its second sample, and the next crossing's first sample. The decision is taken on the edge that accepts that next first sample.
- R7: With cfg_pass=1 on the deciding edge, et_out carries the table entry addressed by the crossing's second sample.
- R8: A table write (tbl_we=1) stores tbl_wdata at tbl_addr only when tbl_load_en=1. Otherwise the entry keeps its old content.
- R9: When a write and a lookup hit the same address on the same edge, the lookup returns the content from before the write.
- R10: et_out holds its value in every cycle where et_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Filter sample qualifier |
| smp_first | input | 1 | Marks the first of a crossing's two samples |
| smp_data | input | 11 | Filtered sample value |
| cfg_pass | input | 1 | 1 = bypass peak test, 0 = peak mode |
| tbl_load_en | input | 1 | Enables table writes |
| tbl_we | input | 1 | Table write request |
| tbl_addr | input | 11 | Table write address |
| tbl_wdata | input | 8 | Table write data |
| et_vld | output | 1 | One pulse per crossing decision |
| et_out | output | 8 | Transverse-energy word |

## Verification
The lookup for one crossing and a table write can fall on the same edge. To provoke this, the bench runs a bypassed crossing with a known second sample. On the clock right after the deciding sample, it writes a new value to that same address. The output must show the entry from before the write. A later crossing with the same address must show the new value, and the behavioural model follows both. The bench also drives plateaus, peaks on either phase, idle gaps inside crossings and random streams in both modes.

// File: rtl/bxpk_pkg.sv
// Shared definitions for the crossing peak finder.
// Assumes: one mode bit selects between peak search and bypass.
package bxpk_pkg;
    typedef enum logic {
        MODE_PEAK = 1'b0,
        MODE_PASS = 1'b1
    } bxpk_mode_e;
endpackage

// File: rtl/bxpk_window.sv
// Three-sample history and per-crossing decision.
// Keeps the last three accepted samples. When the first sample of a
// crossing arrives, it decides on the crossing that just ended, using
// the sample before it and the new sample as neighbours.
// Assumes: exactly two accepted samples per crossing, the first flagged.
module bxpk_window
    import bxpk_pkg::*;
#(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic         in_first,
    input  logic [W-1:0] in_data,
    input  bxpk_mode_e   mode,
    output logic         dec_stb,
    output logic [W-1:0] dec_val,
    output logic         cand_a,
    output logic         cand_b
);
    logic [W-1:0] hist_p;   // sample before the crossing
    logic [W-1:0] hist_a;   // crossing's first sample
    logic [W-1:0] hist_b;   // crossing's second sample
    logic         decide;
    logic         pk_a;
    logic         pk_b;
    logic [W-1:0] pick;

    // Local-maximum tests on both crossing samples, then the value choice.
    always_comb begin
        decide = in_vld && in_first;
        pk_a   = (hist_a > hist_p) && (hist_a >= hist_b);
        pk_b   = (hist_b > hist_a) && (hist_b >= in_data);
        if (mode == MODE_PASS) begin
            pick = hist_b;
        end else if (pk_a) begin
            pick = hist_a;
        end else if (pk_b) begin
            pick = hist_b;
        end else begin
            pick = '0;
        end
    end

    assign cand_a = decide && (mode == MODE_PEAK) && pk_a;
    assign cand_b = decide && (mode == MODE_PEAK) && pk_b;

    // Shift history on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_p <= '0;
            hist_a <= '0;
            hist_b <= '0;
        end else if (in_vld) begin
            hist_p <= hist_a;
            hist_a <= hist_b;
            hist_b <= in_data;
        end
    end

    // Register the decision strobe and value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_stb <= 1'b0;
            dec_val <= '0;
        end else begin
            dec_stb <= decide;
            if (decide) begin
                dec_val <= pick;
            end
        end
    end
endmodule

// File: rtl/bxpk_table.sv
// Calibration table: one write port, one registered read port.
// A read and a write on the same edge return the old content.
// Assumes: contents are loaded before lookups matter (no reset of data).
module bxpk_table #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_vld,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store gated writes.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered lookup, holding the last result between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_vld <= rd_en;
            if (rd_en) begin
                rd_data <= mem[rd_addr];
            end
        end
    end
endmodule

// File: rtl/bxpk_et_top.sv
// Peak finder with energy table, top level.
// Turns a two-samples-per-crossing filter stream into one energy word
// per crossing: decision register, then registered table lookup.
// Assumes: writes to the table are gated by the load enable here.
module bxpk_et_top
    import bxpk_pkg::*;
#(
    parameter int SMP_W = 11,
    parameter int ET_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic             smp_first,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             cfg_pass,
    input  logic             tbl_load_en,
    input  logic             tbl_we,
    input  logic [SMP_W-1:0] tbl_addr,
    input  logic [ET_W-1:0]  tbl_wdata,
    output logic             et_vld,
    output logic [ET_W-1:0]  et_out
);
    bxpk_mode_e       mode;
    logic             win_stb;
    logic [SMP_W-1:0] win_val;
    logic             win_cand_a;
    logic             win_cand_b;
    logic             wr_ok;

    // Mode decode and write gating.
    always_comb begin
        mode  = cfg_pass ? MODE_PASS : MODE_PEAK;
        wr_ok = tbl_we && tbl_load_en;
    end

    bxpk_window #(.W(SMP_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (smp_vld),
        .in_first (smp_first),
        .in_data  (smp_data),
        .mode     (mode),
        .dec_stb  (win_stb),
        .dec_val  (win_val),
        .cand_a   (win_cand_a),
        .cand_b   (win_cand_b)
    );

    bxpk_table #(.AW(SMP_W), .DW(ET_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_addr (tbl_addr),
        .wr_data (tbl_wdata),
        .rd_en   (win_stb),
        .rd_addr (win_val),
        .rd_vld  (et_vld),
        .rd_data (et_out)
    );
endmodule

// File: rtl/bxpk_et_chk.sv
// Assertion checker for bxpk_et_top, attached by bind.
// Assumes: reset is held for at least two clock edges.
module bxpk_et_chk #(
    parameter int SMP_W = 11,
    parameter int ET_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_vld,
    input logic             smp_first,
    input logic [SMP_W-1:0] smp_data,
    input logic             cfg_pass,
    input logic             et_vld,
    input logic [ET_W-1:0]  et_out,
    input logic             win_stb,
    input logic [SMP_W-1:0] win_val,
    input logic             win_cand_a,
    input logic             win_cand_b
);
    logic [SMP_W-1:0] last_smp;

    // Independent copy of the most recent accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_smp <= '0;
        end else if (smp_vld) begin
            last_smp <= smp_data;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!et_vld && et_out == '0));

    p_cadence_r2: assert property (@(posedge clk) disable iff (!rst_n)
        et_vld |-> $past(smp_vld && smp_first, 2));

    p_single_peak_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({win_cand_a, win_cand_b}));

    p_no_peak_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && smp_first && !cfg_pass && !win_cand_a && !win_cand_b)
        |=> (win_stb && win_val == '0));

    p_pass_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && smp_first && cfg_pass) |=> (win_val == $past(last_smp)));

    p_hold_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !et_vld |-> $stable(et_out));
endmodule

bind bxpk_et_top bxpk_et_chk #(.SMP_W(SMP_W), .ET_W(ET_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_vld    (smp_vld),
    .smp_first  (smp_first),
    .smp_data   (smp_data),
    .cfg_pass   (cfg_pass),
    .et_vld     (et_vld),
    .et_out     (et_out),
    .win_stb    (win_stb),
    .win_val    (win_val),
    .win_cand_a (win_cand_a),
    .win_cand_b (win_cand_b)
);

// File: tb/bxpk_et_top_bench.sv
// Bench: a behavioural model compared with the outputs on every clock.
module bxpk_et_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic        smp_first = 1'b0;
    logic [10:0] smp_data = '0;
    logic        cfg_pass = 1'b0;
    logic        tbl_load_en = 1'b0;
    logic        tbl_we = 1'b0;
    logic [10:0] tbl_addr = '0;
    logic [7:0]  tbl_wdata = '0;
    logic        et_vld;
    logic [7:0]  et_out;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    int tbl [2048];
    int hist [$];
    bit pend = 1'b0;
    int pend_addr = 0;
    bit exp_vld = 1'b0;
    int exp_out = 0;

    always #10 clk = ~clk;

    bxpk_et_top u_bxpk_et_top (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_first(smp_first),
        .smp_data(smp_data), .cfg_pass(cfg_pass), .tbl_load_en(tbl_load_en),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .et_vld(et_vld), .et_out(et_out)
    );

    function automatic int curve(input int a);
        return (a * 37 + 11) & 255;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising
    // edge, compare at the next falling edge.
    task automatic step(input bit v, input bit f, input int d, input bit pass,
                        input bit we, input bit ld, input int wa, input int wd);
        int p, a, b, sel;
        smp_vld = v; smp_first = f; smp_data = d[10:0]; cfg_pass = pass;
        tbl_we = we; tbl_load_en = ld; tbl_addr = wa[10:0]; tbl_wdata = wd[7:0];
        @(posedge clk);
        // lookup from last edge's decision reads the table before this edge's write (R9)
        exp_vld = pend;
        if (pend) exp_out = tbl[pend_addr];
        pend = 1'b0;
        if (v && f) begin
            p = hist[0]; a = hist[1]; b = hist[2];
            if (pass) sel = b;
            else if (a > p && a >= b) sel = a;
            else if (b > a && b >= d) sel = b;
            else sel = 0;
            pend = 1'b1;
            pend_addr = sel;
        end
        if (v) begin
            void'(hist.pop_front());
            hist.push_back(d);
        end
        if (we && ld) tbl[wa] = wd;
        @(negedge clk);
        check(et_vld == exp_vld, {cur_req, " R2 vld"}, int'(et_vld), int'(exp_vld));
        check(int'(et_out) == exp_out, {cur_req, " R10 out"}, int'(et_out), exp_out);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // One crossing: two samples, first flagged, optional gap between.
    task automatic xing(input int s0, input int s1, input bit pass, input int gap);
        step(1, 1, s0, pass, 0, 0, 0, 0);
        for (int i = 0; i < gap; i++) step(0, 0, 0, pass, 0, 0, 0, 0);
        step(1, 0, s1, pass, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int old_val;
        hist = '{0, 0, 0};
        for (int i = 0; i < 2048; i++) tbl[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(et_vld == 1'b0, "R1 vld", int'(et_vld), 0);
        check(et_out == 8'd0, "R1 out", int'(et_out), 0);
        rst_n = 1'b1;

        // R8: load the full table
        cur_req = "R8 load";
        for (int i = 0; i < 2048; i++) step(0, 0, 0, 0, 1, 1, i, curve(i));
        // R8: locked write must not change entry 5
        cur_req = "R8 locked";
        step(0, 0, 0, 0, 1, 0, 5, 0);
        xing(1, 5, 1, 0);
        step(1, 1, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        check(int'(et_out) == curve(5), "R8 entry kept", int'(et_out), curve(5));

        // R3/R6: peak on first sample, peak on second sample
        cur_req = "R3 R6";
        xing(10, 50, 0, 0);
        xing(200, 60, 0, 1);
        xing(30, 90, 0, 0);
        xing(40, 20, 0, 2);
        xing(5, 5, 0, 0);
        // R5: monotonic rise gives no peak
        cur_req = "R5";
        xing(10, 20, 0, 0);
        xing(30, 40, 0, 0);
        xing(50, 60, 0, 0);
        step(1, 1, 70, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        check(int'(et_out) == curve(0), "R5 zero entry", int'(et_out), curve(0));
        step(1, 0, 80, 0, 0, 0, 0, 0);
        // R4: plateaus across and within crossings
        cur_req = "R4";
        xing(300, 300, 0, 0);
        xing(300, 100, 0, 0);
        xing(120, 400, 0, 1);
        xing(400, 400, 0, 0);
        xing(10, 10, 0, 0);
        // R7: bypass mode
        cur_req = "R7";
        xing(700, 1234, 1, 0);
        xing(2047, 3, 1, 1);
        step(1, 1, 9, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0, 0);
        check(int'(et_out) == curve(3), "R7 second sample", int'(et_out), curve(3));
        step(1, 0, 2, 1, 0, 0, 0, 0);

        // R9: write and lookup of entry 100 on the same edge
        cur_req = "R9";
        old_val = tbl[100];
        xing(7, 100, 1, 0);
        step(1, 1, 3, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 1, 100, 8'h5A);
        check(int'(et_out) == old_val, "R9 old content", int'(et_out), old_val);
        step(1, 0, 100, 1, 0, 0, 0, 0);
        step(1, 1, 1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0, 0);
        check(et_out == 8'h5A, "R9 new content", int'(et_out), 8'h5A);

        // Mixed random stream in both modes
        cur_req = "R3 R5 R7 random";
        for (int k = 0; k < 400; k++) begin
            int s0, s1;
            s0 = (k % 3 == 0) ? int'($urandom_range(0, 2047)) : int'($urandom_range(0, 6));
            s1 = (k % 5 == 0) ? s0 : int'($urandom_range(0, 6));
            xing(s0, s1, ($urandom_range(0, 3) == 0), int'($urandom_range(0, 2)));
        end
        step(1, 1, 0, 0, 0, 0, 0, 0);
        idle(4);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule